// File: doc/BRIEF.md
# Four-Way Pairwise-Age Replacement Unit

This unit holds the replacement state of a four-way set-associative cache. Every set owns a 6-bit word. Each bit records, for one pair of ways, which of the two was used more recently. The cache controller presents a set index. For that set the unit returns, with no clock delay, the way to evict on the next refill. When the controller strobes a hit or a fill for that set, it also reports the accessed way, and the unit rewrites the set's word on the following clock edge.

A mode input chooses between normal operation, where all four ways compete for eviction, and RAM operation. In RAM operation only ways 0 and 1 hold cached lines, and one bit of the word decides between them. The state is cleared by an active-low power-on reset and is kept through an active-low manual reset. It is also kept through a cache-wide invalidate. Codes that cannot arise from legal updates still decode to a fixed way, so the output is never undefined.

Top module: `pairwise_lru_unit`

## Requirements
- R1: While `por_n` is low, and after it rises, every set holds code 000000. The victim is then way 3 in normal mode and way 1 in RAM mode.
- R2: In normal mode (`ram_mode`=0) the victim follows the set's code, with bit 5 on the left:
  - way 0 for 111000, 111001, 111011, 111100, 111110 and 111111;
  - way 1 for 000110, 000111, 001111, 010110, 011110 and 011111;
  - way 2 for 000001, 000011, 001011, 100001, 101001 and 101011;
  - way 3 for 000000, 000100, 010100, 100000, 110000 and 110100.
- R3: In RAM mode (`ram_mode`=1) the victim is way 0 when bit 5 of the set's code is 1, and way 1 when bit 5 is 0.
- R4: An accepted access to the indexed set updates its code as follows. All other bits are kept.
  - way 0 clears bits 5, 4 and 3;
  - way 1 sets bit 5 and clears bits 2 and 1;
  - way 2 sets bits 4 and 2 and clears bit 0;
  - way 3 sets bits 3, 1 and 0.
- R5: The new code is visible from the clock edge that samples the access. In the cycle of the strobe itself, `victim_way` still reflects the old code.
- R6: An access changes only the code of the set on `set_idx`. All other sets keep their codes.
- R7: While `mrst_n` is low, access strobes are ignored and every code is kept. Once `mrst_n` rises, the codes held before it fell are still in place.
- R8: While `flush` is high, access strobes are ignored and the flush itself leaves every code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all codes |
| mrst_n | input | 1 | Manual reset, active low; blocks updates, keeps codes |
| ram_mode | input | 1 | 1 = two-way RAM mode, 0 = four-way normal mode |
| flush | input | 1 | Cache-wide invalidate; blocks updates in its cycle |
| set_idx | input | SET_W | Set being queried and accessed |
| acc_valid | input | 1 | Hit or fill strobe for the indexed set |
| acc_way | input | 2 | Way that was hit or filled |
| victim_way | output | 2 | Way to replace in the indexed set |

## Verification
The hardest part to reach from the ports is the full set of 24 legal codes. Each one only appears after a particular history of accesses to one set. The stimulus therefore concentrates long random access streams on eight sets, so that every code and every victim row of R2 recurs many times. A reference model tracks the pairwise order of all 64 sets. Its victim prediction is compared on every cycle, including the strobe cycle itself, which exposes any off-by-one in the update timing of R5. Manual reset, flush and a second power-on reset are all applied while strobes keep arriving, and the sets are then swept to show which codes survived.

// File: rtl/lru_pkg.sv
package lru_pkg;

   localparam int NUM_WAYS = 4;
   localparam int WAY_W    = 2;
   localparam int CODE_W   = NUM_WAYS * (NUM_WAYS - 1) / 2;

   typedef logic [WAY_W-1:0]  way_t;
   typedef logic [CODE_W-1:0] code_t;

   // Lower way of the pair tracked by code bit k
   function automatic int pair_lo(input int k);
      case (k)
         5, 4, 3: return 0;
         2, 1:    return 1;
         default: return 2;
      endcase
   endfunction

   // Higher way of the pair tracked by code bit k
   function automatic int pair_hi(input int k);
      case (k)
         5:       return 1;
         4, 2:    return 2;
         default: return 3;
      endcase
   endfunction

endpackage

// File: rtl/lru_code_store.sv
module lru_code_store
   import lru_pkg::*;
#(
   parameter int NUM_SETS = 64,
   localparam int SET_W   = $clog2(NUM_SETS)
) (
   input  logic                           clk,
   input  logic                           por_n,
   input  logic                           wr_en,
   input  logic [SET_W-1:0]               wr_set,
   input  code_t                          wr_code,
   output logic [NUM_SETS-1:0][CODE_W-1:0] codes
);

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            codes[s] <= '0;
         else if (wr_en && (wr_set == SET_W'(s)))
            codes[s] <= wr_code;
      end

      // R6
      untouched_set_chk: assert property (@(posedge clk) disable iff (!por_n)
         !(wr_en && (wr_set == SET_W'(s))) |=> $stable(codes[s]));
   end

endmodule

// File: rtl/lru_code_update.sv
module lru_code_update
   import lru_pkg::*;
(
   input  code_t cur_code,
   input  way_t  way,
   output code_t nxt_code
);

   for (genvar k = 0; k < CODE_W; k++) begin : g_bit
      localparam int LO = pair_lo(k);
      localparam int HI = pair_hi(k);
      always_comb begin
         if (way == WAY_W'(LO))
            nxt_code[k] = 1'b0;
         else if (way == WAY_W'(HI))
            nxt_code[k] = 1'b1;
         else
            nxt_code[k] = cur_code[k];
      end
   end

endmodule

// File: rtl/lru_victim_decode.sv
module lru_victim_decode
   import lru_pkg::*;
(
   input  code_t code,
   input  logic  two_way,
   output way_t  victim
);

   logic hit0, hit1, hit2;

   // way 0 is oldest against 1, 2 and 3
   assign hit0 = code[5] & code[4] & code[3];
   // way 1 is oldest against 0, 2 and 3
   assign hit1 = ~code[5] & code[2] & code[1];
   // way 2 is oldest against 0, 1 and 3
   assign hit2 = ~code[4] & ~code[2] & code[0];

   always_comb begin
      if (two_way)
         victim = code[5] ? 2'd0 : 2'd1;
      else if (hit0)
         victim = 2'd0;
      else if (hit1)
         victim = 2'd1;
      else if (hit2)
         victim = 2'd2;
      else
         victim = 2'd3;
   end

   // R3
   always_comb begin
      two_way_range_chk: assert (!two_way || $isunknown(code) || victim[1] == 1'b0);
   end

endmodule

// File: rtl/pairwise_lru_unit.sv
module pairwise_lru_unit
   import lru_pkg::*;
#(
   parameter int NUM_SETS = 64,
   localparam int SET_W   = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             ram_mode,
   input  logic             flush,
   input  logic [SET_W-1:0] set_idx,
   input  logic             acc_valid,
   input  logic [1:0]       acc_way,
   output logic [1:0]       victim_way
);

   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (NUM_WAYS != 4 || CODE_W != 6) begin : g_bad_ways
      $error("pairwise code is defined for four ways only");
   end

   logic [NUM_SETS-1:0][CODE_W-1:0] codes;
   code_t cur_code;
   code_t nxt_code;
   logic  upd_en;

   assign upd_en   = acc_valid & mrst_n & ~flush;
   assign cur_code = codes[set_idx];

   lru_code_store #(.NUM_SETS(NUM_SETS)) i_store (
      .clk     (clk),
      .por_n   (por_n),
      .wr_en   (upd_en),
      .wr_set  (set_idx),
      .wr_code (nxt_code),
      .codes   (codes)
   );

   lru_code_update i_update (
      .cur_code (cur_code),
      .way      (acc_way),
      .nxt_code (nxt_code)
   );

   lru_victim_decode i_decode (
      .code    (cur_code),
      .two_way (ram_mode),
      .victim  (victim_way)
   );

   // R4
   way0_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
      (acc_valid && mrst_n && !flush && acc_way == 2'd0)
      |=> codes[$past(set_idx)][5:3] == 3'b000);

   // R4
   way3_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
      (acc_valid && mrst_n && !flush && acc_way == 2'd3)
      |=> (codes[$past(set_idx)][3] && codes[$past(set_idx)][1] && codes[$past(set_idx)][0]));

   // R7
   manual_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> $stable(codes));

   // R8
   flush_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      flush |=> $stable(codes));

endmodule

// File: tb/test_pairwise_lru_unit.sv
module test_pairwise_lru_unit;

   localparam int SETS = 64;
   localparam int SW   = $clog2(SETS);

   logic          clk = 1'b0;
   logic          por_n, mrst_n, ram_mode, flush, acc_valid;
   logic [SW-1:0] set_idx;
   logic [1:0]    acc_way;
   logic [1:0]    victim_way;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;
   logic [5:0] mdl [SETS];

   always #5 clk = ~clk;

   pairwise_lru_unit #(.NUM_SETS(SETS)) i_pairwise_lru_unit (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .ram_mode(ram_mode),
      .flush(flush), .set_idx(set_idx), .acc_valid(acc_valid),
      .acc_way(acc_way), .victim_way(victim_way)
   );

   function automatic int exp_victim(logic [5:0] c, bit ram);
      if (ram) return c[5] ? 0 : 1;
      case (c)
         6'b000000, 6'b000100, 6'b010100, 6'b100000, 6'b110000, 6'b110100: return 3;
         6'b000001, 6'b000011, 6'b001011, 6'b100001, 6'b101001, 6'b101011: return 2;
         6'b000110, 6'b000111, 6'b001111, 6'b010110, 6'b011110, 6'b011111: return 1;
         6'b111000, 6'b111001, 6'b111011, 6'b111100, 6'b111110, 6'b111111: return 0;
         default: return -1;
      endcase
   endfunction

   // pairwise order: bit of pair (a,b) is 1 when b was used after a
   function automatic logic [5:0] mdl_touch(logic [5:0] c, int w);
      logic [5:0] r;
      int k;
      r = c;
      k = 5;
      for (int a = 0; a < 4; a++) begin
         for (int b = a + 1; b < 4; b++) begin
            if (w == a) r[k] = 1'b0;
            else if (w == b) r[k] = 1'b1;
            k--;
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s victim_way=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input bit v, input int w, input int s, input bit ram,
                       input bit fl, input bit mr, input string tag);
      @(negedge clk);
      acc_valid = v;
      acc_way   = 2'(w);
      set_idx   = SW'(s);
      ram_mode  = ram;
      flush     = fl;
      mrst_n    = mr;
      #1;
      check(tag, int'(victim_way), exp_victim(mdl[s], ram));
      @(posedge clk);
      if (por_n && mr && !fl && v) mdl[s] = mdl_touch(mdl[s], w);
   endtask

   task automatic power_on();
      @(negedge clk);
      por_n = 1'b0;
      acc_valid = 1'b0;
      repeat (2) @(negedge clk);
      for (int s = 0; s < SETS; s++) mdl[s] = '0;
      por_n = 1'b1;
   endtask

   task automatic sweep(input bit ram, input string tag);
      for (int s = 0; s < SETS; s++) step(0, 0, s, ram, 0, 1, tag);
   endtask

   initial begin
      por_n = 1'b0; mrst_n = 1'b1; ram_mode = 1'b0; flush = 1'b0;
      acc_valid = 1'b0; acc_way = '0; set_idx = '0;
      power_on();
      // R1: cleared codes in both modes
      sweep(0, "R1");
      sweep(1, "R1");
      // R5: strobe cycle shows old code, next cycle new code (001011 -> way 2)
      step(1, 3, 5, 0, 0, 1, "R5");
      step(0, 0, 5, 0, 0, 1, "R5");
      check("R5", int'(victim_way), 2);
      // R2, R4: long random streams on a few sets
      for (int i = 0; i < 600; i++)
         step($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 7), 0, 0, 1, "R2");
      // R6: untouched sets still cleared, touched ones as modelled
      sweep(0, "R6");
      // R3: two-way operation
      for (int i = 0; i < 200; i++)
         step(1, $urandom_range(0, 1), $urandom_range(8, 11), 1, 0, 1, "R3");
      sweep(1, "R3");
      // R7: strobes during manual reset are ignored, codes survive
      for (int i = 0; i < 30; i++)
         step(1, $urandom_range(0, 3), $urandom_range(0, 11), 0, 0, 0, "R7");
      sweep(0, "R7");
      // R8: strobes during flush are ignored, codes survive
      for (int i = 0; i < 30; i++)
         step(1, $urandom_range(0, 3), $urandom_range(0, 11), 0, 1, 1, "R8");
      sweep(0, "R8");
      // R1: a second power-on reset clears everything again
      power_on();
      sweep(0, "R1");
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule